// File: doc/BRIEF.md
# CPU Sleep Handshake Sequencer

This block takes a small processor system into a hardware sleep state and brings it back out. Firmware writes a 1 to the sleep control bit. The block then raises a bus-halt request to the CPU and waits for the CPU's acknowledge. Once the acknowledge has been sampled, the block asserts a system-wide power-down signal on the next falling clock edge. Power-down switches off the gated enables of the flash, the fast oscillator, the input transient filter and the voltage reference, and it stops the fast system clock.

Some circuits are never gated: the low-power oscillator, the reference refresh logic and the supply monitor. The external crystal enable is driven only by its own control bit.

A wake event first removes power-down. The block then counts a programmable number of low-power-oscillator ticks so the clocks can settle. After that it drops the bus request and clears the sleep bit, and the CPU resumes.

Top module: `cpu_sleep_seq`

## Requirements
- R1: A write of 1 to the sleep bit (`sleep_wr_i`=1, `sleep_wdata_i`=1) while awake raises `bus_req_o` combinationally in the same cycle. A write of 0 leaves `bus_req_o` low.
- R2: Once raised, `bus_req_o` stays high, and `sleep_bit_o` reads 1 from the rising edge that takes the write, until the wake sequence finishes.
- R3: `pd_o` rises only on the falling clock edge that follows the rising edge at which `bus_ack_i` was sampled high. Without an acknowledge, `pd_o` stays low.
- R4: While `pd_o` is high, every bit of `gated_en_o` is 0. Bit 0 is flash, bit 1 the fast oscillator, bit 2 the input filter and bit 3 the voltage reference. While `pd_o` is low, all of these bits are 1.
- R5: `aon_en_o` (low-power oscillator, reference refresh, supply monitor) is 1 at all times, including during power-down.
- R6: `xtal_en_o` takes `xtal_wdata_i` at the rising edge where `xtal_wr_i` is high. It does not change otherwise, and power-down leaves it unchanged.
- R7: `sysclk_en_o` is 0 while `pd_o` is high and 1 otherwise.
- R8: A sleep-bit write is ignored while a sequence is in progress. A wake pulse is ignored while awake.
- R9: After reset, `bus_req_o`=0, `pd_o`=0, `sleep_bit_o`=0, `gated_en_o` is all ones, `sysclk_en_o`=1 and `xtal_en_o`=0.
- R10: A wake sampled while asleep clears `pd_o` at the next falling edge. `bus_req_o` and `sleep_bit_o` fall on the first rising edge at which `pd_o` is low and `settle_cycles_i` ticks of `lp_tick_i` have been counted since the wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_wr_i | input | 1 | Write strobe for the sleep control bit |
| sleep_wdata_i | input | 1 | Data written to the sleep control bit |
| xtal_wr_i | input | 1 | Write strobe for the crystal enable bit |
| xtal_wdata_i | input | 1 | Data written to the crystal enable bit |
| settle_cycles_i | input | CNT_W | Number of low-power ticks to wait after wake |
| lp_tick_i | input | 1 | One-cycle pulse per low-power oscillator period |
| wake_i | input | 1 | Wake event |
| bus_ack_i | input | 1 | Bus-halt acknowledge from the CPU |
| bus_req_o | output | 1 | Bus-halt request to the CPU |
| sleep_bit_o | output | 1 | Readback of the sleep control bit |
| pd_o | output | 1 | System-wide power-down |
| gated_en_o | output | N_GATED | Enables of the gated circuits |
| sysclk_en_o | output | 1 | Fast system clock run enable |
| aon_en_o | output | 1 | Enable of the always-on circuits |
| xtal_en_o | output | 1 | External crystal enable |

## Verification
The assertions assume that the CPU holds `bus_ack_i` only in answer to a request. They also assume that `settle_cycles_i` stays constant while a sequence is running, because the settle check compares the count against the live input.

The bench meets these assumptions in three ways:
- a CPU model derives the acknowledge from the request through two registers and can be stalled;
- the settle count is changed only while the block is awake;
- all inputs are driven one nanosecond after a rising edge, and the falling-edge power-down is observed half a period later.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;
  typedef enum logic [2:0] {
    ST_AWAKE  = 3'd0,
    ST_REQ    = 3'd1,
    ST_PDWAIT = 3'd2,
    ST_SLEEP  = 3'd3,
    ST_SETTLE = 3'd4
  } seq_state_e;

  localparam int GATE_FLASH = 0;
  localparam int GATE_FOSC  = 1;
  localparam int GATE_FILT  = 2;
  localparam int GATE_VREF  = 3;
  localparam int GATE_NUM   = 4;
endpackage

// File: rtl/sleep_seq_fsm.sv
module sleep_seq_fsm
  import sleep_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_wr_i,
  input  logic             sleep_wdata_i,
  input  logic             bus_ack_i,
  input  logic             wake_i,
  input  logic             lp_tick_i,
  input  logic [CNT_W-1:0] settle_cycles_i,
  input  logic             pd_i,
  output seq_state_e       state_o,
  output logic             sleep_bit_o,
  output logic             bus_req_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sleep_q;
  logic             set_req, settle_done;

  assign set_req     = (state_q == ST_AWAKE) && sleep_wr_i && sleep_wdata_i;
  assign settle_done = (state_q == ST_SETTLE) && !pd_i && (cnt_q == settle_cycles_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_AWAKE:  if (set_req)     state_d = ST_REQ;
      ST_REQ:    if (bus_ack_i)   state_d = ST_PDWAIT;
      ST_PDWAIT:                  state_d = ST_SLEEP;
      ST_SLEEP:  if (wake_i)      state_d = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_d = ST_AWAKE;
      default:                    state_d = ST_AWAKE;
    endcase
  end

  // tick counter runs only while settling, saturates at full scale
  always_comb begin
    cnt_d = '0;
    if (state_q == ST_SETTLE && !settle_done) begin
      cnt_d = cnt_q;
      if (lp_tick_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_AWAKE;
      cnt_q   <= '0;
      sleep_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (set_req)          sleep_q <= 1'b1;
      else if (settle_done) sleep_q <= 1'b0;
    end
  end

  assign state_o     = state_q;
  assign sleep_bit_o = sleep_q;
  assign bus_req_o   = sleep_q | set_req;

  AST_NO_PD_WITHOUT_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REQ && !bus_ack_i) |=> (state_q != ST_PDWAIT)); // R3
  AST_SETTLE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE && state_d == ST_AWAKE) |-> (cnt_q == settle_cycles_i && !pd_i)); // R10
  AST_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_AWAKE && state_q != ST_SETTLE) |=> sleep_q); // R8
endmodule

// File: rtl/sleep_pd_edge.sv
module sleep_pd_edge
  import sleep_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  seq_state_e state_i,
  output logic       pd_o
);
  logic pd_q;

  // power-down changes only on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pd_q <= 1'b0;
    else         pd_q <= (state_i == ST_PDWAIT) || (state_i == ST_SLEEP);
  end

  assign pd_o = pd_q;

  AST_PD_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_q) |-> (state_i == ST_PDWAIT)); // R3
  AST_PD_DROP_ON_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pd_q) |-> (state_i == ST_SETTLE)); // R10
endmodule

// File: rtl/sleep_enable_gate.sv
module sleep_enable_gate #(
  parameter int N_GATED = 4
) (
  input  logic               pd_i,
  output logic [N_GATED-1:0] gated_en_o,
  output logic               sysclk_en_o,
  output logic               aon_en_o
);
  for (genvar g = 0; g < N_GATED; g++) begin : g_gate
    assign gated_en_o[g] = ~pd_i;
  end

  assign sysclk_en_o = ~pd_i;
  assign aon_en_o    = 1'b1;
endmodule

// File: rtl/cpu_sleep_seq.sv
module cpu_sleep_seq
  import sleep_seq_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int N_GATED = GATE_NUM
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_wr_i,
  input  logic               sleep_wdata_i,
  input  logic               xtal_wr_i,
  input  logic               xtal_wdata_i,
  input  logic [CNT_W-1:0]   settle_cycles_i,
  input  logic               lp_tick_i,
  input  logic               wake_i,
  input  logic               bus_ack_i,
  output logic               bus_req_o,
  output logic               sleep_bit_o,
  output logic               pd_o,
  output logic [N_GATED-1:0] gated_en_o,
  output logic               sysclk_en_o,
  output logic               aon_en_o,
  output logic               xtal_en_o
);
  seq_state_e state;
  logic       pd;
  logic       xtal_q;

  sleep_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sleep_wr_i      (sleep_wr_i),
    .sleep_wdata_i   (sleep_wdata_i),
    .bus_ack_i       (bus_ack_i),
    .wake_i          (wake_i),
    .lp_tick_i       (lp_tick_i),
    .settle_cycles_i (settle_cycles_i),
    .pd_i            (pd),
    .state_o         (state),
    .sleep_bit_o     (sleep_bit_o),
    .bus_req_o       (bus_req_o)
  );

  sleep_pd_edge u_pd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .pd_o    (pd)
  );

  sleep_enable_gate #(.N_GATED(N_GATED)) u_gate (
    .pd_i        (pd),
    .gated_en_o  (gated_en_o),
    .sysclk_en_o (sysclk_en_o),
    .aon_en_o    (aon_en_o)
  );

  // crystal enable has its own bit, untouched by power-down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        xtal_q <= 1'b0;
    else if (xtal_wr_i) xtal_q <= xtal_wdata_i;
  end

  assign xtal_en_o = xtal_q;
  assign pd_o      = pd;

  AST_REQ_HELD_IN_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd |-> bus_req_o); // R2
  AST_GATES_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd |-> (gated_en_o == '0 && !sysclk_en_o && aon_en_o)); // R4
  AST_XTAL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xtal_wr_i |=> $stable(xtal_en_o)); // R6
  AST_RELEASE_AFTER_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_req_o) |-> (!pd && $past(!pd))); // R10
endmodule

// File: tb/cpu_sleep_seq_tb_top.sv
`timescale 1ns/1ps
module cpu_sleep_seq_tb_top;
  localparam int CNT_W = 8;
  localparam int NG    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_wr = 0, sleep_wdata = 0, xtal_wr = 0, xtal_wdata = 0;
  logic [CNT_W-1:0] settle = '0;
  logic lp_tick = 0, wake = 0;
  logic bus_ack, bus_req, sleep_bit, pd, sysclk_en, aon_en, xtal_en;
  logic [NG-1:0] gated_en;
  logic cpu_smp, stall = 1'b0;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cpu_sleep_seq #(.CNT_W(CNT_W), .N_GATED(NG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_wr_i(sleep_wr), .sleep_wdata_i(sleep_wdata),
    .xtal_wr_i(xtal_wr), .xtal_wdata_i(xtal_wdata), .settle_cycles_i(settle),
    .lp_tick_i(lp_tick), .wake_i(wake), .bus_ack_i(bus_ack), .bus_req_o(bus_req),
    .sleep_bit_o(sleep_bit), .pd_o(pd), .gated_en_o(gated_en), .sysclk_en_o(sysclk_en),
    .aon_en_o(aon_en), .xtal_en_o(xtal_en));

  // CPU model: samples request on a rising edge, acknowledges on the next
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin cpu_smp <= 1'b0; bus_ack <= 1'b0; end
    else begin cpu_smp <= bus_req & ~stall; bus_ack <= cpu_smp; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk("R9 req", bus_req, 0);
    chk("R9 pd", pd, 0);
    chk("R9 sleep_bit", sleep_bit, 0);
    chk("R9 gated", gated_en, 4'hF);
    chk("R9 sysclk", sysclk_en, 1);
    chk("R9 xtal", xtal_en, 0);
    chk("R5 aon", aon_en, 1);
  endtask

  task automatic t_write_zero_and_wake_awake;
    sleep_wr = 1; sleep_wdata = 0; #0.5;
    chk("R1 zero write no req", bus_req, 0);
    step(1); sleep_wr = 0;
    wake = 1; step(1); wake = 0;
    step(3);
    chk("R8 wake awake req", bus_req, 0);
    chk("R8 wake awake pd", pd, 0);
    chk("R8 wake awake bit", sleep_bit, 0);
  endtask

  task automatic t_enter_sleep(input logic xtal_exp);
    sleep_wr = 1; sleep_wdata = 1; #0.5;
    chk("R1 immediate req", bus_req, 1);
    chk("R2 bit not yet", sleep_bit, 0);
    step(1); sleep_wr = 0;
    chk("R2 bit set", sleep_bit, 1);
    chk("R3 pd before ack", pd, 0);
    step(1);
    chk("R3 ack raised", bus_ack, 1);
    chk("R3 pd not yet", pd, 0);
    step(1);
    chk("R3 pd waits falling edge", pd, 0);
    #2;
    chk("R3 pd at falling edge", pd, 1);
    chk("R4 gated off", gated_en, 4'h0);
    chk("R7 sysclk off", sysclk_en, 0);
    chk("R5 aon on", aon_en, 1);
    chk("R6 xtal kept", xtal_en, xtal_exp);
    chk("R2 req held", bus_req, 1);
    step(1);
  endtask

  task automatic t_ignore_write;
    sleep_wr = 1; sleep_wdata = 0;
    step(1); sleep_wr = 0;
    step(2);
    chk("R8 bit kept", sleep_bit, 1);
    chk("R8 pd kept", pd, 1);
    chk("R8 req kept", bus_req, 1);
  endtask

  task automatic t_wake_zero;
    wake = 1; step(1); wake = 0;
    chk("R10 pd still high", pd, 1);
    chk("R10 req still high", bus_req, 1);
    #2;
    chk("R10 pd cleared first", pd, 0);
    chk("R10 req held", bus_req, 1);
    chk("R4 gated back on", gated_en, 4'hF);
    chk("R7 sysclk back on", sysclk_en, 1);
    step(1);
    chk("R10 req released", bus_req, 0);
    chk("R10 bit cleared", sleep_bit, 0);
  endtask

  task automatic t_wake_settle;
    wake = 1; step(1); wake = 0;
    #2;
    chk("R10 pd low settle", pd, 0);
    step(1);
    step(2);
    chk("R10 idle no count", bus_req, 1);
    for (int i = 0; i < 3; i++) begin
      lp_tick = 1; step(1); lp_tick = 0;
      chk("R10 req during settle", bus_req, 1);
      step(1);
      if (i < 2) chk("R10 req during settle gap", bus_req, 1);
    end
    chk("R10 released after ticks", bus_req, 0);
    chk("R10 bit cleared after ticks", sleep_bit, 0);
  endtask

  task automatic t_no_ack;
    stall = 1;
    sleep_wr = 1; sleep_wdata = 1; step(1); sleep_wr = 0;
    step(8);
    chk("R3 no ack no pd", pd, 0);
    chk("R2 req waits", bus_req, 1);
    stall = 0;
    step(3); #2;
    chk("R3 pd after late ack", pd, 1);
    step(1);
  endtask

  task automatic t_xtal;
    xtal_wr = 1; xtal_wdata = 1; step(1); xtal_wr = 0;
    chk("R6 xtal set", xtal_en, 1);
  endtask

  initial begin
    step(2); rst_n = 1'b1; step(1);
    t_reset();
    t_write_zero_and_wake_awake();
    t_xtal();
    t_enter_sleep(1'b1);
    t_ignore_write();
    t_wake_zero();
    step(4);
    settle = 8'd3;
    t_enter_sleep(1'b1);
    t_wake_settle();
    step(4);
    settle = 8'd0;
    t_no_ack();
    t_wake_zero();
    chk("R6 xtal unchanged", xtal_en, 1);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule